// File: doc/BRIEF.md
# Memory-Mapped Machine Timer with Compare

This block keeps a 64-bit real-time count and a 64-bit compare value, and raises a machine timer interrupt whenever the count has reached the compare value. The count advances by one in every clock cycle where the tick-enable input is high. A platform divider drives that input at a constant rate, so the count does not depend on core stalls or clock gating. A read-only word reports the tick frequency, which software uses to turn counts into time.

Software reaches every value over a simple 32-bit bus with one write strobe and one read strobe. Each 64-bit value appears as two 32-bit words. The interrupt is a level: it stays high while the count is at or above the compare value. Software acknowledges it by writing a larger compare value.

Top module: `rt_timer`

## Requirements
- R1: After synchronous reset the count is 0, the compare value is all ones, and `irq_timer` is low.
- R2: The count increases by exactly 1 on each rising clock edge where `tick_en` is high and no count word is written. Otherwise it holds.
- R3: When the low count word wraps from 0xFFFFFFFF to 0, the high count word increases by 1 on that same edge.
- R4: While `bus_re` is high, `bus_rdata` shows the selected word in the same cycle: 0x00 count bits 31:0, 0x04 count bits 63:32, 0x08 compare bits 31:0, 0x0C compare bits 63:32, 0x10 tick frequency. Any other address, including one with address bits 1:0 not zero, reads 0. While `bus_re` is low, `bus_rdata` is 0.
- R5: A write to one 32-bit word of the count or of the compare value changes only that word. The other word keeps its value.
- R6: A write to a count word in a cycle where `tick_en` is high wins. The written word takes the written data, the other word is unchanged, and no increment happens on that edge.
- R7: `irq_timer` is high in exactly those cycles where the count, as an unsigned 64-bit number, is greater than or equal to the compare value. This includes equality. It follows a register change in the same cycle the new value appears.
- R8: Once `irq_timer` is high, it stays high until a write lowers the count or raises the compare value above the count. Further ticks do not clear it.
- R9: The tick-frequency word is read-only. Writes to 0x10, to unmapped addresses, or to addresses with bits 1:0 not zero change no register.
- R10: The comparison is unsigned. A compare value with bit 63 set is larger than any count with bit 63 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the count on this edge |
| bus_addr | input | ADDR_W (5) | Byte address of the selected word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, takes effect at the rising edge |
| bus_re | input | 1 | Read strobe, data is returned in the same cycle |
| bus_rdata | output | 32 | Read data |
| irq_timer | output | 1 | Machine timer interrupt, level |

## Verification
The bench builds the block with the default 64-bit count, a 32-bit bus and a 5-bit address, so both halves of each value and the unmapped space above 0x10 can be reached. It sets its own tick frequency of 1,000,000, so the read-only word returns a value that differs from the default. Because the count can be preloaded through the bus, the low-word carry and the equality edge of the comparison are reached within a few cycles, without waiting for a long run of ticks.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    parameter int unsigned BUS_W      = 32;
    parameter int unsigned TIME_W     = 64;
    parameter int unsigned NHALF      = TIME_W / BUS_W;
    parameter int unsigned HALF_IDX_W = (NHALF > 1) ? $clog2(NHALF) : 1;
    parameter int unsigned BYTES_W    = $clog2(BUS_W / 8);

    typedef enum logic [1:0] {
        RG_NONE,
        RG_CNT,
        RG_CMP,
        RG_TBASE
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [HALF_IDX_W-1:0]   half;
    } target_t;

    typedef struct packed {
        logic                    wr;
        logic [HALF_IDX_W-1:0]   half;
        logic [BUS_W-1:0]        data;
    } half_wr_t;

    // Word index -> register region and half. Counter words first, then
    // compare words, then the timebase word.
    function automatic target_t map_word(input int unsigned word);
        target_t t;
        t.region = RG_NONE;
        t.half   = '0;
        if (word < NHALF) begin
            t.region = RG_CNT;
            t.half   = HALF_IDX_W'(word);
        end else if (word < 2 * NHALF) begin
            t.region = RG_CMP;
            t.half   = HALF_IDX_W'(word - NHALF);
        end else if (word == 2 * NHALF) begin
            t.region = RG_TBASE;
        end
        return t;
    endfunction

    function automatic logic [TIME_W-1:0] merge_half(
        input logic [TIME_W-1:0] old_v,
        input half_wr_t          w
    );
        logic [TIME_W-1:0] r;
        r = old_v;
        for (int i = 0; i < NHALF; i++) begin
            if (HALF_IDX_W'(i) == w.half) begin
                r[i*BUS_W +: BUS_W] = w.data;
            end
        end
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] pick_half(
        input logic [TIME_W-1:0]     v,
        input logic [HALF_IDX_W-1:0] idx
    );
        logic [BUS_W-1:0] r;
        r = '0;
        for (int i = 0; i < NHALF; i++) begin
            if (HALF_IDX_W'(i) == idx) begin
                r = v[i*BUS_W +: BUS_W];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    output target_t           target,
    output half_wr_t          cnt_wr,
    output half_wr_t          cmp_wr
);

    logic aligned;

    always_comb begin
        aligned = (addr[BYTES_W-1:0] == '0);
        if (aligned) begin
            target = map_word(int'(addr[ADDR_W-1:BYTES_W]));
        end else begin
            target.region = RG_NONE;
            target.half   = '0;
        end

        cnt_wr.wr   = we && (target.region == RG_CNT);
        cnt_wr.half = target.half;
        cnt_wr.data = wdata;

        cmp_wr.wr   = we && (target.region == RG_CMP);
        cmp_wr.half = target.half;
        cmp_wr.data = wdata;
    end

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  half_wr_t          wr,
    output logic [TIME_W-1:0] cnt
);

    // A full-width add: the carry out of the low word reaches the high
    // word on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr.wr) begin
            cnt <= merge_half(cnt, wr);
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  half_wr_t          wr,
    input  logic [TIME_W-1:0] cnt,
    output logic [TIME_W-1:0] cmp,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '1;
        end else if (wr.wr) begin
            cmp <= merge_half(cmp, wr);
        end
    end

    // Unsigned level comparison.
    always_comb begin
        irq = (cnt >= cmp);
    end

endmodule

// File: rtl/rt_timer.sv
module rt_timer
    import mtmr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned TICK_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_timer
);

    target_t           target;
    half_wr_t          cnt_wr;
    half_wr_t          cmp_wr;
    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] cmp_q;

    mtmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .target (target),
        .cnt_wr (cnt_wr),
        .cmp_wr (cmp_wr)
    );

    mtmr_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr      (cnt_wr),
        .cnt     (cnt_q)
    );

    mtmr_compare u_compare (
        .clk (clk),
        .rst (rst),
        .wr  (cmp_wr),
        .cnt (cnt_q),
        .cmp (cmp_q),
        .irq (irq_timer)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (target.region)
                RG_CNT:   bus_rdata = pick_half(cnt_q, target.half);
                RG_CMP:   bus_rdata = pick_half(cmp_q, target.half);
                RG_TBASE: bus_rdata = BUS_W'(TICK_HZ);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk
    import mtmr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned TICK_HZ = 24_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq_timer,
    input logic [TIME_W-1:0] cnt,
    input logic [TIME_W-1:0] cmp
);

    localparam int unsigned CNT_END = NHALF * (BUS_W / 8);
    localparam int unsigned CMP_END = 2 * CNT_END;

    logic aligned;
    logic cnt_hit;
    logic cmp_hit;

    always_comb begin
        aligned = (bus_addr[BYTES_W-1:0] == '0);
        cnt_hit = bus_we && aligned && (bus_addr < ADDR_W'(CNT_END));
        cmp_hit = bus_we && aligned && (bus_addr >= ADDR_W'(CNT_END))
                  && (bus_addr < ADDR_W'(CMP_END));
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (cmp == '1) && !irq_timer);

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_hit) |=> cnt == $past(cnt) + 1'b1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_hit) |=> $stable(cnt));

    // R6
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == '0) |=> cnt[BUS_W-1:0] == $past(bus_wdata));

    // R5
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_hit |=> $stable(cmp));

    // R8
    irq_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_timer && !cnt_hit && !cmp_hit && cnt != '1) |=> irq_timer);

    // R4
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == '0);

    // R9
    tbase_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADDR_W'(CMP_END)) |-> bus_rdata == BUS_W'(TICK_HZ));

endmodule

bind rt_timer mtmr_chk #(.ADDR_W(ADDR_W), .TICK_HZ(TICK_HZ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_timer (irq_timer),
    .cnt       (cnt_q),
    .cmp       (cmp_q)
);

// File: tb/rt_timer_bench.sv
module rt_timer_bench;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned TICK_HZ    = 1_000_000;

    localparam logic [4:0] A_CLO = 5'h00;
    localparam logic [4:0] A_CHI = 5'h04;
    localparam logic [4:0] A_MLO = 5'h08;
    localparam logic [4:0] A_MHI = 5'h0C;
    localparam logic [4:0] A_TB  = 5'h10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic              irq_timer;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rt_timer #(.ADDR_W(ADDR_W), .TICK_HZ(TICK_HZ)) u_rt_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_timer (irq_timer)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        bus_re   = 1'b1;
        #1;
        check(tag, bus_rdata, exp);
        bus_re   = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        #1;
        check(tag, {31'd0, irq_timer}, {31'd0, exp});
    endtask

    task automatic t_reset();
        rd_chk("R1 count low after reset", A_CLO, 32'h0);
        rd_chk("R1 count high after reset", A_CHI, 32'h0);
        rd_chk("R1 compare low after reset", A_MLO, 32'hFFFF_FFFF);
        rd_chk("R1 compare high after reset", A_MHI, 32'hFFFF_FFFF);
        irq_chk("R1 irq low after reset", 1'b0);
        rd_chk("R4 timebase word", A_TB, TICK_HZ);
    endtask

    task automatic t_tick();
        repeat (5) @(negedge clk);
        rd_chk("R2 no advance without tick", A_CLO, 32'h0);
        ticks(7);
        rd_chk("R2 seven ticks", A_CLO, 32'd7);
    endtask

    task automatic t_carry();
        wr(A_CHI, 32'd5);
        rd_chk("R5 low word kept on high write", A_CLO, 32'd7);
        wr(A_CLO, 32'hFFFF_FFFE);
        rd_chk("R5 high word kept on low write", A_CHI, 32'd5);
        ticks(2);
        rd_chk("R3 low word wrapped", A_CLO, 32'h0);
        rd_chk("R3 carry into high word", A_CHI, 32'd6);
    endtask

    task automatic t_write_wins();
        tick_en = 1'b1;
        wr(A_CLO, 32'h100);
        tick_en = 1'b0;
        rd_chk("R6 written low word, no increment", A_CLO, 32'h100);
        rd_chk("R6 high word untouched", A_CHI, 32'd6);
    endtask

    task automatic t_irq();
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'h10);
        wr(A_MHI, 32'h0);
        wr(A_MLO, 32'h20);
        rd_chk("R5 compare high written", A_MHI, 32'h0);
        rd_chk("R5 compare low written", A_MLO, 32'h20);
        irq_chk("R7 count below compare", 1'b0);
        ticks(15);
        irq_chk("R7 count one below compare", 1'b0);
        ticks(1);
        irq_chk("R7 count equal to compare", 1'b1);
        ticks(3);
        irq_chk("R8 irq held across ticks", 1'b1);
        wr(A_MLO, 32'h100);
        irq_chk("R8 irq cleared by larger compare", 1'b0);
        wr(A_MLO, 32'h22);
        irq_chk("R7 irq raised by smaller compare", 1'b1);
        wr(A_MLO, 32'h100);
    endtask

    task automatic t_unsigned();
        wr(A_MHI, 32'h8000_0000);
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 32'h7FFF_FFFF);
        irq_chk("R10 compare with top bit set is larger", 1'b0);
        wr(A_CHI, 32'h9000_0000);
        irq_chk("R10 count with top bit set above compare", 1'b1);
    endtask

    task automatic t_ignore();
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'h1234);
        wr(A_TB, 32'hDEAD_BEEF);
        wr(5'h14, 32'hDEAD_BEEF);
        wr(5'h01, 32'hDEAD_BEEF);
        wr(5'h09, 32'hDEAD_BEEF);
        rd_chk("R9 timebase unchanged by write", A_TB, TICK_HZ);
        rd_chk("R9 count low unchanged", A_CLO, 32'h1234);
        rd_chk("R9 count high unchanged", A_CHI, 32'h0);
        rd_chk("R9 compare low unchanged", A_MLO, 32'h100);
        rd_chk("R9 compare high unchanged", A_MHI, 32'h8000_0000);
        rd_chk("R4 unmapped address reads zero", 5'h14, 32'h0);
        rd_chk("R4 misaligned address reads zero", 5'h02, 32'h0);
        bus_addr = A_TB;
        #1;
        check("R4 no read strobe gives zero", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tick();
        t_carry();
        t_write_wins();
        t_irq();
        t_unsigned();
        t_ignore();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule